// File: doc/BRIEF.md
# Data-Change Clock-Gated Register

This block is a parameterised N-bit storage register. Its clock reaches the flops only when a functional enable is high and the value waiting on the data input differs from the value already stored. A per-bit difference detector compares every incoming bit with the matching stored bit, and a single reduction tree collapses the result to one "something would change" flag. That flag is combined with the enable to form a gate request.

The request is held in a level-sensitive latch that is open while the clock is low and closed while it is high. The latch output is ANDed with the clock to give a gated clock free of glitches. The latched request is brought out as `gclk_en`, so a test environment can count the clock pulses that actually reach the register.

A parameter selects the gating rule. In change-gated mode, rewriting the stored value does not toggle the clock. In enable-only mode, every enabled cycle produces a pulse. Reset is active-low: asserting it clears the register at once, and releasing it takes effect on the clock through a two-stage synchroniser.

Top module: `dcg_reg`

## Requirements
- R1: While `rst_n` is low, `q` reads all zeros immediately, whatever the state of `en`, `d` and the gate.
- R2: When `en` is high and `d` differs from `q` in the low phase before a rising edge, `gclk_en` is 1 for that edge and `q` equals that `d` after it.
- R3: When `en` is low during the low phase before an edge, `gclk_en` is 0 for that edge and `q` keeps its value.
- R4: In change-gated mode (`MODE = GATE_ON_CHANGE`), `en` high with `d` equal to `q` gives `gclk_en` 0 and no clock pulse, and `q` is unchanged.
- R5: In enable-only mode (`MODE = GATE_ON_ENABLE`), `en` high gives a clock pulse even when `d` equals `q`, and `q` still ends equal to `d`.
- R6: `gclk_en` changes only while `clk` is low. After a load edge it stays 1 through the high phase, even though `d` now equals `q`.
- R7: A difference in any single bit position is enough to open the gate, from bit 0 up to bit WIDTH-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, released through a synchroniser |
| en | input | 1 | Functional write enable |
| d | input | WIDTH | Data to store |
| q | output | WIDTH | Stored value |
| gclk_en | output | 1 | Latched gate request; 1 means the coming rising edge reaches the register |

## Verification
The bench builds two copies of the block. One is a 16-bit register in change-gated mode. The other is an 8-bit register in enable-only mode, fed the low byte of the same stimulus. Driving both with one stream puts the two gating rules side by side for the same unchanged write. The first copy suppresses the pulse and the second produces one. The 16-bit width lets single-bit changes at the top and bottom positions be checked separately. The bench also applies a reset in mid-run while `en` is held high and the data keeps changing.

// File: rtl/dcg_pkg.sv
package dcg_pkg;
  typedef enum logic {
    GATE_ON_CHANGE = 1'b0,
    GATE_ON_ENABLE = 1'b1
  } gate_mode_e;
endpackage

// File: rtl/dcg_rst_sync.sv
module dcg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dcg_change_det.sv
module dcg_change_det #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] nxt,
  output logic             differs
);
  logic [WIDTH-1:0] bit_diff;

  genvar gi;
  generate
    for (gi = 0; gi < WIDTH; gi++) begin : g_bit
      assign bit_diff[gi] = cur[gi] ^ nxt[gi];
    end
  endgenerate

  assign differs = |bit_diff;
endmodule

// File: rtl/dcg_clk_gate.sv
module dcg_clk_gate (
  input  logic clk,
  input  logic req,
  output logic en_lat,
  output logic gclk
);
  always_latch begin
    if (!clk) en_lat <= req;
  end

  assign gclk = clk & en_lat;
endmodule

// File: rtl/dcg_store.sv
module dcg_store #(
  parameter int WIDTH = 16
) (
  input  logic             gclk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = d;
  end

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/dcg_reg.sv
module dcg_reg
  import dcg_pkg::*;
#(
  parameter int         WIDTH = 16,
  parameter gate_mode_e MODE  = GATE_ON_CHANGE
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q,
  output logic             gclk_en
);
  logic rst_sync_n;
  logic differs;
  logic gate_req;
  logic gclk;

  dcg_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_sync_n)
  );

  dcg_change_det #(.WIDTH(WIDTH)) u_change_det (
    .cur    (q),
    .nxt    (d),
    .differs(differs)
  );

  generate
    if (MODE == GATE_ON_CHANGE) begin : g_change_mode
      assign gate_req = en & differs;
    end else begin : g_enable_mode
      assign gate_req = en;
    end
  endgenerate

  dcg_clk_gate u_clk_gate (
    .clk   (clk),
    .req   (gate_req),
    .en_lat(gclk_en),
    .gclk  (gclk)
  );

  dcg_store #(.WIDTH(WIDTH)) u_store (
    .gclk (gclk),
    .rst_n(rst_sync_n),
    .d    (d),
    .q    (q)
  );

  // R1: reset holds the register cleared
  p_reset_clear_r1: assert property (@(posedge clk) !rst_n |-> (q == '0))
    else $error("p_reset_clear_r1");

  // R2: an opened gate loads the data seen at that edge
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    gclk_en |=> (q == $past(d)))
    else $error("p_load_r2");

  // R3: a closed gate keeps the stored value
  p_hold_idle_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !gclk_en |=> $stable(q))
    else $error("p_hold_idle_r3");

  // R3: no pulse without the enable
  p_need_enable_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    gclk_en |-> en)
    else $error("p_need_enable_r3");

  generate
    if (MODE == GATE_ON_CHANGE) begin : g_chk_change
      // R4: no pulse unless some bit would change
      p_need_change_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
        gclk_en |-> (d != q))
        else $error("p_need_change_r4");
    end else begin : g_chk_enable
      // R5: enable alone opens the gate
      p_enable_opens_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
        en |-> gclk_en)
        else $error("p_enable_opens_r5");
    end
  endgenerate
endmodule

// File: tb/dcg_reg_bench.sv
module dcg_reg_bench;
  import dcg_pkg::*;

  localparam int WA = 16;
  localparam int WB = 8;

  typedef struct {
    logic [WA-1:0] qa;
    logic          pa;
    logic [WB-1:0] qb;
    logic          pb;
    string         tag;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en;
  logic [WA-1:0] d;
  logic [WA-1:0] qa;
  logic [WB-1:0] qb;
  logic          ga, gb;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    pulses_a = 0, pulses_b = 0, exp_pa = 0, exp_pb = 0;
  bit    mon_on = 1'b0;
  bit    done = 1'b0;
  item_t sb[$];
  logic [WA-1:0] model_a;
  logic [WB-1:0] model_b;

  always #5 clk = ~clk;

  dcg_reg #(.WIDTH(WA), .MODE(GATE_ON_CHANGE)) u_dcg_reg (
    .clk(clk), .rst_n(rst_n), .en(en), .d(d), .q(qa), .gclk_en(ga));

  dcg_reg #(.WIDTH(WB), .MODE(GATE_ON_ENABLE)) u_dcg_reg_en (
    .clk(clk), .rst_n(rst_n), .en(en), .d(d[WB-1:0]), .q(qb), .gclk_en(gb));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [WA-1:0] v, input logic e, input string tag);
    item_t it;
    @(negedge clk);
    #1;
    d  = v;
    en = e;
    it.pa = e && (v != model_a);
    if (it.pa) model_a = v;
    it.pb = e;
    if (it.pb) model_b = v[WB-1:0];
    it.qa = model_a;
    it.qb = model_b;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: gate sampled late in the low phase, data after the edge
  initial begin
    logic sa, sbg;
    item_t it;
    forever begin
      @(negedge clk);
      #4;
      sa  = ga;
      sbg = gb;
      @(posedge clk);
      #2;
      if (mon_on && sb.size() > 0) begin
        it = sb.pop_front();
        if (sa) pulses_a++;
        if (sbg) pulses_b++;
        if (it.pa) exp_pa++;
        if (it.pb) exp_pb++;
        chk(sa == it.pa, {it.tag, " gate A"}, 32'(sa), 32'(it.pa));
        chk(qa == it.qa, {it.tag, " q A"}, 32'(qa), 32'(it.qa));
        chk(sbg == it.pb, {it.tag, " R5 gate B"}, 32'(sbg), 32'(it.pb));
        chk(qb == it.qb, {it.tag, " R5 q B"}, 32'(qb), 32'(it.qb));
        // R6: latched request holds through the high phase after a load
        if (it.pa) chk(ga == 1'b1, "R6 hold high phase", 32'(ga), 32'd1);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    finish_run();
  end

  initial begin
    model_a = '0;
    model_b = '0;
    en = 1'b0;
    d  = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk(qa == '0, "R1 reset A", 32'(qa), 32'd0);
    chk(qb == '0, "R1 reset B", 32'(qb), 32'd0);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;

    wr(16'h1234, 1'b1, "R2 load");
    wr(16'h1234, 1'b1, "R4 same data");
    wr(16'hBEEF, 1'b0, "R3 disabled");
    wr(16'hBEEF, 1'b0, "R3 disabled");
    wr(16'h9234, 1'b1, "R7 msb only");
    wr(16'h9235, 1'b1, "R7 lsb only");
    wr(16'h9235, 1'b1, "R4 repeat");
    wr(16'h0000, 1'b1, "R2 clear");
    for (int i = 0; i < 40; i++) begin
      logic [WA-1:0] v;
      v = 16'((i * 16'h3B71) ^ (i << 9));
      if (i % 4 == 1) v = model_a;
      wr(v, (i % 3) != 2, "R2 pattern");
    end
    for (int b = 0; b < WA; b++) begin
      wr(model_a ^ (16'h1 << b), 1'b1, "R7 single bit");
    end
    wr(model_a, 1'b0, "R3 idle");
    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    chk(pulses_a == exp_pa, "R4 pulse total A", 32'(pulses_a), 32'(exp_pa));
    chk(pulses_b == exp_pb, "R5 pulse total B", 32'(pulses_b), 32'(exp_pb));

    // mid-run reset with writes still enabled
    @(posedge clk);
    #3;
    rst_n = 1'b0;
    #1;
    chk(qa == '0, "R1 async clear A", 32'(qa), 32'd0);
    chk(qb == '0, "R1 async clear B", 32'(qb), 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      en = 1'b1;
      d  = 16'hA5A5 + 16'(k);
      @(posedge clk);
      #2;
      chk(qa == '0, "R1 held under reset", 32'(qa), 32'd0);
    end
    @(negedge clk);
    #1;
    en = 1'b0;
    rst_n = 1'b1;
    model_a = '0;
    model_b = '0;
    repeat (3) @(negedge clk);
    mon_on = 1'b1;
    wr(16'h00F0, 1'b1, "R2 after reset");
    wr(16'h00F0, 1'b1, "R4 after reset");
    wr(16'h00F0, 1'b0, "R3 after reset");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule